// File: doc/BRIEF.md
# Selectable-Power Dither Injector

This block sits in front of the word-length truncator of an audio DAC modulator. Each accepted stereo sample gets a pseudo-random noise term added to it before the low bits are dropped. The noise breaks up the correlation between the signal and the truncation error, which would otherwise show up as idle tones. A 2-bit mode input turns the noise off or selects one of three power levels spaced about 3 dB apart. Each level is a trade between tone suppression and lost dynamic range.

The noise comes from a 23-bit maximal-length shift register. The register steps once for every accepted sample, in every mode. The left and right channels take separate byte slices of it, so the two channels carry different noise. Each slice is scaled by a small shift-and-add gain and added to the full-width input. The sum is clamped at full scale and then truncated.

A two-state flow machine paces the output. In ST_IDLE no result is pending. The transition T_ACCEPT (an in_valid while idle) enters ST_EMIT, which presents a result for one cycle. From ST_EMIT, T_STREAM (another in_valid) stays in ST_EMIT, and T_DRAIN (no in_valid) returns to ST_IDLE.

Top module: `dither_inject`

## Requirements
- R1: out_valid is high exactly in the cycle after each cycle with in_valid high, and low otherwise. While no sample is accepted, out_left and out_right keep their last values.
- R2: With dith_mode 2'b00, each output equals bits [IN_W-1:IN_W-OUT_W] of the matching input. This is plain truncation, with no noise.
- R3: dith_mode 2'b01 applies gain constant 7, giving a uniform noise RMS of about -30 dBFS (referenced to peak full scale).
- R4: dith_mode 2'b10 applies gain constant 10, giving about -27 dBFS.
- R5: dith_mode 2'b11 applies gain constant 14, giving about -24 dBFS.
- R6: The noise term is raw × gain × 2^(IN_W-15), where raw is the channel's noise byte read as two's complement. It is added to the full-width input before truncation, and truncation takes the floor.
- R7: The noise generator is 23 bits wide and holds 23'h01ACE5 after reset. It steps only on an accepted sample, in any mode, as next = {s[21:0], s[22]^s[17]}. A sample uses the state held before its own step. Left raw is s[7:0] and right raw is s[22:15].
- R8: A sum above 2^(IN_W-1)-1 or below -2^(IN_W-1) is clamped to that limit before truncation and never wraps.
- R9: During and right after reset, out_valid, out_left and out_right are 0.
- R10: The mode is taken with each sample, so consecutive samples may use different modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A stereo sample is presented this cycle |
| in_left | input | IN_W | Left input sample, two's complement |
| in_right | input | IN_W | Right input sample, two's complement |
| dith_mode | input | 2 | Noise level select (00 off, 01/10/11 rising power) |
| out_valid | output | 1 | Truncated result valid |
| out_left | output | OUT_W | Left truncated output |
| out_right | output | OUT_W | Right truncated output |

## Verification
Noise injection and clamping can both act on the same sample. The bench provokes this by streaming inputs at the positive and negative limits back to back in the highest mode. Only samples whose noise byte has the right sign clip, so both the clamped and the unclamped path are exercised within one burst. The scoreboard predicts every result from its own model of the shift register and the gain rule. A clipped value therefore has to match the limit exactly, and the next sample in the stream has to show the register stepped once.

// File: rtl/dith_pkg.sv
`timescale 1ns/1ps
package dith_pkg;
    typedef enum logic [1:0] {
        DM_OFF  = 2'b00,
        DM_LOW  = 2'b01,
        DM_MID  = 2'b10,
        DM_HIGH = 2'b11
    } dith_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } flow_state_e;

    localparam int GAIN_W = 4;
    localparam int RAW_W  = 8;

    // Shift-and-add gain per level: 7 = 4+2+1, 10 = 8+2, 14 = 8+4+2
    function automatic logic [GAIN_W-1:0] mode_gain(input dith_mode_e m);
        logic [GAIN_W-1:0] g;
        unique case (m)
            DM_OFF:  g = 4'd0;
            DM_LOW:  g = 4'd7;
            DM_MID:  g = 4'd10;
            DM_HIGH: g = 4'd14;
            default: g = 4'd0;
        endcase
        return g;
    endfunction
endpackage

// File: rtl/dith_lfsr.sv
`timescale 1ns/1ps
module dith_lfsr #(
    parameter int              W     = 23,
    parameter int              TAP_A = 22,
    parameter int              TAP_B = 17,
    parameter logic [W-1:0]    SEED  = 23'h01ACE5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] state
);
    logic [W-1:0] state_q;
    logic         fb;

    assign fb = state_q[TAP_A] ^ state_q[TAP_B];

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEED;
        else if (step)
            state_q <= {state_q[W-2:0], fb};
    end

    assign state = state_q;
endmodule

// File: rtl/dith_chan.sv
`timescale 1ns/1ps
module dith_chan
    import dith_pkg::*;
#(
    parameter int IN_W  = 24,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]   sample,
    input  logic [RAW_W-1:0]  raw,
    input  logic [GAIN_W-1:0] gain,
    output logic [OUT_W-1:0]  trunc
);
    localparam int SH    = IN_W - 15;
    localparam int SCL_W = RAW_W + GAIN_W + 1;
    localparam int SUM_W = IN_W + 1;

    logic signed [SCL_W-1:0] raw_ext;
    logic signed [SCL_W-1:0] scaled;
    logic signed [SUM_W-1:0] noise;
    logic signed [SUM_W-1:0] sum;
    logic        [IN_W-1:0]  sat;
    logic                    unused_low;

    assign raw_ext = {{(SCL_W-RAW_W){raw[RAW_W-1]}}, raw};

    always_comb begin
        scaled = '0;
        for (int b = 0; b < GAIN_W; b++) begin
            if (gain[b])
                scaled = scaled + (raw_ext <<< b);
        end
    end

    assign noise = {{(SUM_W-SCL_W){scaled[SCL_W-1]}}, scaled} <<< SH;
    assign sum   = {sample[IN_W-1], sample} + noise;

    always_comb begin
        if (sum[SUM_W-1] != sum[SUM_W-2])
            sat = sum[SUM_W-1] ? {1'b1, {(IN_W-1){1'b0}}}
                               : {1'b0, {(IN_W-1){1'b1}}};
        else
            sat = sum[IN_W-1:0];
    end

    assign trunc      = sat[IN_W-1 -: OUT_W];
    assign unused_low = ^sat[IN_W-OUT_W-1:0];
endmodule

// File: rtl/dither_inject.sv
`timescale 1ns/1ps
module dither_inject
    import dith_pkg::*;
#(
    parameter int                IN_W   = 24,
    parameter int                OUT_W  = 16,
    parameter int                LFSR_W = 23,
    parameter logic [LFSR_W-1:0] SEED   = 23'h01ACE5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_left,
    input  logic [IN_W-1:0]  in_right,
    input  logic [1:0]       dith_mode,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_left,
    output logic [OUT_W-1:0] out_right
);
    localparam int NCH = 2;

    flow_state_e       state_q, state_d;
    logic [LFSR_W-1:0] lfsr_q;
    logic [GAIN_W-1:0] gain;
    logic [IN_W-1:0]   samp  [NCH];
    logic [RAW_W-1:0]  raw   [NCH];
    logic [OUT_W-1:0]  trunc [NCH];
    logic              unused_lfsr_mid;

    dith_lfsr #(
        .W(LFSR_W), .TAP_A(LFSR_W-1), .TAP_B(LFSR_W-6), .SEED(SEED)
    ) u_lfsr (
        .clk(clk), .rst_n(rst_n), .step(in_valid), .state(lfsr_q)
    );

    assign gain    = mode_gain(dith_mode_e'(dith_mode));
    assign samp[0] = in_left;
    assign samp[1] = in_right;
    assign raw[0]  = lfsr_q[RAW_W-1:0];
    assign raw[1]  = lfsr_q[LFSR_W-1 -: RAW_W];
    assign unused_lfsr_mid = ^lfsr_q[LFSR_W-RAW_W-1:RAW_W];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dith_chan #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chan (
            .sample(samp[c]), .raw(raw[c]), .gain(gain), .trunc(trunc[c])
        );
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_EMIT;   // T_ACCEPT
            ST_EMIT: if (!in_valid) state_d = ST_IDLE;  // T_DRAIN (else T_STREAM)
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_left  <= '0;
            out_right <= '0;
        end else if (in_valid) begin
            out_left  <= trunc[0];
            out_right <= trunc[1];
        end
    end

    assign out_valid = (state_q == ST_EMIT);
endmodule

// File: rtl/dither_inject_chk.sv
`timescale 1ns/1ps
module dither_inject_chk #(
    parameter int IN_W   = 24,
    parameter int OUT_W  = 16,
    parameter int LFSR_W = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [IN_W-1:0]   in_left,
    input logic [1:0]        dith_mode,
    input logic              out_valid,
    input logic [OUT_W-1:0]  out_left,
    input logic [OUT_W-1:0]  out_right,
    input logic [LFSR_W-1:0] lfsr_q
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);  // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_left) && $stable(out_right)));  // R1
    AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dith_mode == 2'b00) |=> (out_left == $past(in_left[IN_W-1 -: OUT_W])));  // R2
    AST_NO_WRAP_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_left[IN_W-1] && in_left[IN_W-2]) |=> !out_left[OUT_W-1]);  // R8
    AST_NO_WRAP_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_left[IN_W-1] && !in_left[IN_W-2]) |=> out_left[OUT_W-1]);  // R8
    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);  // R7
    AST_LFSR_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(lfsr_q));  // R7
endmodule

bind dither_inject dither_inject_chk #(
    .IN_W(IN_W), .OUT_W(OUT_W), .LFSR_W(LFSR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
    .dith_mode(dith_mode), .out_valid(out_valid), .out_left(out_left),
    .out_right(out_right), .lfsr_q(lfsr_q)
);

// File: tb/dither_inject_tb.sv
`timescale 1ns/1ps
module dither_inject_tb;
    localparam int IN_W = 24;
    localparam int OUT_W = 16;

    typedef struct {
        logic [OUT_W-1:0] l;
        logic [OUT_W-1:0] r;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  in_left = '0;
    logic [IN_W-1:0]  in_right = '0;
    logic [1:0]       dith_mode = 2'b00;
    logic             out_valid;
    logic [OUT_W-1:0] out_left, out_right;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t sb[$];
    logic [22:0] model;
    logic [OUT_W-1:0] last_l = '0, last_r = '0;

    always #10 clk = ~clk;

    dither_inject u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .dith_mode(dith_mode), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected truncated value from R2..R6, R8
    function automatic logic [OUT_W-1:0] predict(input logic [IN_W-1:0] s,
                                                 input logic [7:0] raw, input logic [1:0] m);
        longint g, d, sum;
        logic [63:0] bits;
        g = (m == 2'b01) ? 7 : (m == 2'b10) ? 10 : (m == 2'b11) ? 14 : 0;
        d = longint'($signed(raw)) * g * 512;
        sum = longint'($signed(s)) + d;
        if (sum > 64'sd8388607)  sum = 64'sd8388607;
        if (sum < -64'sd8388608) sum = -64'sd8388608;
        bits = sum;
        return bits[23:8];
    endfunction

    task automatic send(input logic [IN_W-1:0] l, input logic [IN_W-1:0] r,
                        input logic [1:0] m, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_left = l; in_right = r; dith_mode = m;
        e.l = predict(l, model[7:0], m);
        e.r = predict(r, model[22:15], m);
        e.tag = tag;
        sb.push_back(e);
        model = {model[21:0], model[22] ^ model[17]};
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_left = 24'hA5A5A5 ^ IN_W'(i * 977);
            in_right = ~in_left;
            dith_mode = 2'(i);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        model = 23'h01ACE5;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
        chk(out_left == '0 && out_right == '0, "R9 outputs", {out_left, out_right}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 after release", out_valid, 0);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R1 unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(out_left == e.l, {e.tag, " left"}, out_left, e.l);
                chk(out_right == e.r, {e.tag, " right"}, out_right, e.r);
                last_l = out_left; last_r = out_right;
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2: plain truncation
        send(24'h123456, 24'hFEDCBA, 2'b00, "R2 bypass a");
        send(24'hFFFFFF, 24'h000001, 2'b00, "R2 bypass b");
        send(24'h7FFFFF, 24'h800000, 2'b00, "R2 bypass limits");
        send(24'h0000FF, 24'hFFFF00, 2'b00, "R2 bypass low bits");
        idle(1);
        chk(out_valid == 1'b1, "R1 valid one cycle late", out_valid, 1);
        idle(3);
        chk(out_valid == 1'b0, "R1 no valid while idle", out_valid, 0);
        chk(out_left == last_l && out_right == last_r, "R1 hold while idle",
            {out_left, out_right}, {last_l, last_r});
        // R3/R4/R5 levels, R6 injection, R7 continued sequence
        for (int i = 0; i < 6; i++) send(IN_W'(i * 24'h21357), IN_W'(-i * 24'h13579), 2'b01, "R3 low level");
        for (int i = 0; i < 6; i++) send(IN_W'(i * 24'h31415), IN_W'(24'h400000 - i), 2'b10, "R4 mid level");
        for (int i = 0; i < 6; i++) send(IN_W'(-i * 24'h27182), IN_W'(i * 24'h11111), 2'b11, "R5 high level");
        idle(2);
        // R8: saturation together with injection
        for (int i = 0; i < 8; i++) send(24'h7FFFFF, 24'h800000, 2'b11, "R8 clamp burst");
        for (int i = 0; i < 4; i++) send(24'h7FF000, 24'h801000, 2'b10, "R8 near limit");
        // R10: per-sample mode changes, R6 across modes
        for (int i = 0; i < 8; i++) send(IN_W'(24'h0ABCDE + i * 24'h55), IN_W'(24'hF12345 - i * 24'h99), 2'(i), "R10 mode switch");
        idle(4);
        // R7: seed restored after a second reset, used by first sample
        do_reset();
        send(24'h000000, 24'h000000, 2'b11, "R7 seed after reset");
        send(24'h000000, 24'h000000, 2'b11, "R7 first step");
        idle(3);
        chk(sb.size() == 0, "R1 all results delivered", sb.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule